// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces the horizontal sync, vertical sync, composite sync and blanking signals for a raster display. It runs on the pixel clock. A pixel counter steps through each line and a line counter steps through each frame. Every timing value is taken at run time from three parameter words, so one netlist can drive any display format whose fields fit the widths.

Each axis runs through four phases in a fixed order: sync, gate delay (back porch), visible gate, and front porch. The front porch lasts until the counter reaches the programmed total, and then the counter wraps. Every field holds its length minus one. The block also gives a pixel-valid strobe to the downstream pixel path, and one-cycle end-of-line and end-of-frame pulses for the interrupt and frame-buffer bank-switch logic. The sync, composite sync and blank outputs each have their own polarity bit.

While the enable input is low, both counters stay at zero and every output sits at its inactive level. After enable rises, the position counting starts again from the top-left corner.

Top module: `vtg_top`

## Requirements
- R1: Field positions are fixed. In the horizontal word `h_param` and in the vertical word `v_param`, bits [31:24] hold the sync width minus one, bits [23:16] hold the gate delay minus one, and bits [15:0] hold the visible gate length minus one. In `len_param`, bits [31:16] hold the last pixel index of a line and bits [15:0] hold the last line index of a frame.
- R2: A line is `len_param[31:16]`+1 clocks long. `eol_o` is high for exactly one cycle, in the cycle that shows the last pixel position of a line.
- R3: Pixel positions 0 to S are in horizontal sync, where S is the horizontal sync field. The active level is high before the polarity bit is applied.
- R4: Horizontal positions from S+D+2 to S+D+G+2 are visible, where D is the gate delay field and G is the gate field. Vertical visibility uses the same bounds, counted in lines.
- R5: The line counter advances once per completed line and wraps after `len_param[15:0]`. Lines 0 to the vertical sync field are in vertical sync.
- R6: `pix_valid_o` is high only when both axes are visible. The active-level blank is its complement.
- R7: Setting `pol_hs`, `pol_vs`, `pol_cs` or `pol_bl` inverts `hsync_o`, `vsync_o`, `csync_o` or `blank_o` respectively, and only that output.
- R8: The active-level composite sync is the XOR of the active-level horizontal and vertical syncs.
- R9: While `en` is low, or during reset, `pix_valid_o`, `eol_o` and `eof_o` are 0 and each of the four polarised outputs equals its polarity bit.
- R10: `eof_o` is high for exactly one cycle per frame, in the cycle that shows the last pixel of the last line.
- R11: The outputs after the k-th rising edge with `en` high (k counted from 0) show pixel position k of the frame. A re-enable therefore restarts at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable. Low holds the counters at zero |
| h_param | input | 32 | Horizontal sync, gate delay and gate fields |
| v_param | input | 32 | Vertical sync, gate delay and gate fields |
| len_param | input | 32 | Horizontal total (upper half) and vertical total (lower half) |
| pol_hs | input | 1 | Invert hsync_o |
| pol_vs | input | 1 | Invert vsync_o |
| pol_cs | input | 1 | Invert csync_o |
| pol_bl | input | 1 | Invert blank_o |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Blanking, active outside the visible window |
| pix_valid_o | output | 1 | Pixel data valid strobe, active high |
| eol_o | output | 1 | One-cycle end-of-line pulse |
| eof_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The block is run with five timing sets. Each set uses different sync, gate delay and gate values and a different polarity mask, so a swapped field, a bound that is off by one, or a polarity bit routed to the wrong output gives a different waveform. One set fills the line and the frame up to the total with no front porch, which tests the visible upper bound at the wrap. Another set has a one-pixel gate and a one-line gate. Directed cases cover the reset levels, a disable in the middle of a line, and the restart at position 0 that follows it.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int CNT_W  = 16;
    localparam int SYNC_W = 8;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_VIS   = 2'd2,
        PH_FRONT = 2'd3
    } phase_e;

    // Active-high video strobes before any polarity is applied
    typedef struct packed {
        logic hs;
        logic vs;
        logic blank;
        logic valid;
        logic eol;
        logic eof;
    } vid_t;

    localparam vid_t VID_IDLE = '{hs: 1'b0, vs: 1'b0, blank: 1'b0,
                                  valid: 1'b0, eol: 1'b0, eof: 1'b0};

    // Phase of a position c given the sync, delay and gate fields (all count-1)
    function automatic phase_e phase_of(input logic [31:0] c,
                                        input logic [31:0] s,
                                        input logic [31:0] g,
                                        input logic [31:0] w);
        logic [33:0] back_end;
        logic [33:0] vis_end;
        back_end = {2'b00, s} + {2'b00, g} + 34'd1;
        vis_end  = back_end + {2'b00, w} + 34'd1;
        if ({2'b00, c} <= {2'b00, s})
            return PH_SYNC;
        else if ({2'b00, c} <= back_end)
            return PH_BACK;
        else if ({2'b00, c} <= vis_end)
            return PH_VIS;
        else
            return PH_FRONT;
    endfunction

endpackage

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SYNC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    input  logic [SW-1:0] f_sync,
    input  logic [SW-1:0] f_gdel,
    input  logic [CW-1:0] f_gate,
    input  logic [CW-1:0] f_tot,
    output phase_e        phase,
    output logic          last
);

    logic [CW-1:0] cnt;

    assign last  = (cnt == f_tot);
    assign phase = phase_of(32'(cnt), 32'(f_sync), 32'(f_gdel), 32'(f_gate));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv)
            cnt <= last ? '0 : cnt + 1'b1;
    end

    // R2 / R5: the counter wraps to zero after its programmed total
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && last) |=> (cnt == '0));

    // R5: the counter steps by one below its total
    a_r5_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && !last) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/vtg_polar.sv
module vtg_polar
    import vtg_pkg::*;
(
    input  vid_t q,
    input  logic pol_hs,
    input  logic pol_vs,
    input  logic pol_cs,
    input  logic pol_bl,
    output logic hsync_o,
    output logic vsync_o,
    output logic csync_o,
    output logic blank_o
);

    always_comb begin
        hsync_o = q.hs ^ pol_hs;
        vsync_o = q.vs ^ pol_vs;
        csync_o = (q.hs ^ q.vs) ^ pol_cs;
        blank_o = q.blank ^ pol_bl;
    end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SYNC_W,
    localparam int GATE_LO = 0,
    localparam int GDEL_LO = CW,
    localparam int SYNC_LO = CW + SW,
    localparam int WORD_W  = CW + 2 * SW,
    localparam int LEN_W   = 2 * CW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] h_param,
    input  logic [WORD_W-1:0] v_param,
    input  logic [LEN_W-1:0]  len_param,
    input  logic              pol_hs,
    input  logic              pol_vs,
    input  logic              pol_cs,
    input  logic              pol_bl,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              csync_o,
    output logic              blank_o,
    output logic              pix_valid_o,
    output logic              eol_o,
    output logic              eof_o
);

    phase_e h_ph, v_ph;
    logic   h_last, v_last;
    vid_t   vid_q;

    vtg_axis #(.CW(CW), .SW(SW)) u_hax (
        .clk    (clk),
        .rst    (rst),
        .clr    (!en),
        .adv    (en),
        .f_sync (h_param[SYNC_LO +: SW]),
        .f_gdel (h_param[GDEL_LO +: SW]),
        .f_gate (h_param[GATE_LO +: CW]),
        .f_tot  (len_param[CW +: CW]),
        .phase  (h_ph),
        .last   (h_last)
    );

    vtg_axis #(.CW(CW), .SW(SW)) u_vax (
        .clk    (clk),
        .rst    (rst),
        .clr    (!en),
        .adv    (en && h_last),
        .f_sync (v_param[SYNC_LO +: SW]),
        .f_gdel (v_param[GDEL_LO +: SW]),
        .f_gate (v_param[GATE_LO +: CW]),
        .f_tot  (len_param[0 +: CW]),
        .phase  (v_ph),
        .last   (v_last)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            vid_q <= VID_IDLE;
        end else begin
            vid_q.hs    <= (h_ph == PH_SYNC);
            vid_q.vs    <= (v_ph == PH_SYNC);
            vid_q.valid <= (h_ph == PH_VIS) && (v_ph == PH_VIS);
            vid_q.blank <= !((h_ph == PH_VIS) && (v_ph == PH_VIS));
            vid_q.eol   <= h_last;
            vid_q.eof   <= h_last && v_last;
        end
    end

    vtg_polar u_pol (
        .q       (vid_q),
        .pol_hs  (pol_hs),
        .pol_vs  (pol_vs),
        .pol_cs  (pol_cs),
        .pol_bl  (pol_bl),
        .hsync_o (hsync_o),
        .vsync_o (vsync_o),
        .csync_o (csync_o),
        .blank_o (blank_o)
    );

    assign pix_valid_o = vid_q.valid;
    assign eol_o       = vid_q.eol;
    assign eof_o       = vid_q.eof;

    // R9: a disabled cycle leaves the strobes low on the next edge
    a_r9_idle_strobes: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pix_valid_o && !eol_o && !eof_o));

    // R10: the frame end always falls on a line end
    a_r10_eof_on_eol: assert property (@(posedge clk) disable iff (rst)
        eof_o |-> eol_o);

    // R2: the line end is a single-cycle pulse when a line is longer than one pixel
    a_r2_eol_pulse: assert property (@(posedge clk) disable iff (rst)
        (eol_o && (len_param[CW +: CW] != '0)) |=> !eol_o);

    // R6: valid pixels are never flagged as blanked
    a_r6_valid_unblanked: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |-> (blank_o == pol_bl));

endmodule

// File: tb/sim_vtg_top.sv
module sim_vtg_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    typedef struct packed {
        logic [7:0]  hs;
        logic [7:0]  hg;
        logic [15:0] hgate;
        logic [15:0] htot;
        logic [7:0]  vs;
        logic [7:0]  vg;
        logic [15:0] vgate;
        logic [15:0] vtot;
        logic [3:0]  pol;   // {bl, cs, vs, hs}
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{8'd1, 8'd1, 16'd7, 16'd15, 8'd0, 8'd1, 16'd3, 16'd7,  4'b0000},
        '{8'd0, 8'd0, 16'd3, 16'd6,  8'd1, 8'd0, 16'd2, 16'd6,  4'b1111},
        '{8'd2, 8'd3, 16'd9, 16'd20, 8'd2, 8'd1, 16'd4, 16'd10, 4'b0101},
        '{8'd0, 8'd0, 16'd5, 16'd7,  8'd0, 8'd0, 16'd1, 16'd3,  4'b1010},
        '{8'd3, 8'd0, 16'd0, 16'd9,  8'd0, 8'd2, 16'd0, 16'd5,  4'b0011}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] h_param = '0;
    logic [31:0] v_param = '0;
    logic [31:0] len_param = '0;
    logic        pol_hs = 1'b0, pol_vs = 1'b0, pol_cs = 1'b0, pol_bl = 1'b0;
    logic        hsync_o, vsync_o, csync_o, blank_o, pix_valid_o, eol_o, eof_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vtg_top u0 (
        .clk(clk), .rst(rst), .en(en),
        .h_param(h_param), .v_param(v_param), .len_param(len_param),
        .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_cs(pol_cs), .pol_bl(pol_bl),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .csync_o(csync_o),
        .blank_o(blank_o), .pix_valid_o(pix_valid_o),
        .eol_o(eol_o), .eof_o(eof_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // 0 sync, 1 back porch, 2 visible, 3 front porch
    function automatic int ph(input int c, input int s, input int g, input int w);
        if (c <= s) return 0;
        if (c <= s + g + 1) return 1;
        if (c <= s + g + w + 2) return 2;
        return 3;
    endfunction

    task automatic load_vec(input vec_t v);
        h_param   = {v.hs, v.hg, v.hgate};
        v_param   = {v.vs, v.vg, v.vgate};
        len_param = {v.htot, v.vtot};
        {pol_bl, pol_cs, pol_vs, pol_hs} = v.pol;
    endtask

    task automatic run_vec(input int idx);
        vec_t v;
        int hl, vl, n;
        int m_hs, m_vs, m_cs, m_bl, m_pv, m_eol, m_eof;
        v = VECS[idx];
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        load_vec(v);
        @(negedge clk); en = 1'b1;
        hl = int'(v.htot) + 1;
        vl = int'(v.vtot) + 1;
        n  = 2 * hl * vl;
        m_hs = 0; m_vs = 0; m_cs = 0; m_bl = 0; m_pv = 0; m_eol = 0; m_eof = 0;
        for (int k = 0; k < n; k++) begin
            int h, ln;
            bit hs_a, vs_a, vis, e_l, e_f;
            @(negedge clk);
            h    = k % hl;
            ln   = (k / hl) % vl;
            hs_a = (ph(h, v.hs, v.hg, v.hgate) == 0);
            vs_a = (ph(ln, v.vs, v.vg, v.vgate) == 0);
            vis  = (ph(h, v.hs, v.hg, v.hgate) == 2) && (ph(ln, v.vs, v.vg, v.vgate) == 2);
            e_l  = (h == hl - 1);
            e_f  = e_l && (ln == vl - 1);
            if (hsync_o !== (hs_a ^ v.pol[0])) m_hs++;
            if (vsync_o !== (vs_a ^ v.pol[1])) m_vs++;
            if (csync_o !== ((hs_a ^ vs_a) ^ v.pol[2])) m_cs++;
            if (blank_o !== ((!vis) ^ v.pol[3])) m_bl++;
            if (pix_valid_o !== vis) m_pv++;
            if (eol_o !== e_l) m_eol++;
            if (eof_o !== e_f) m_eof++;
        end
        $display("vector %0d: %0d pixel positions compared", idx, n);
        chk($sformatf("R1 R3 R7 hsync mismatches vec%0d", idx), m_hs, 0);
        chk($sformatf("R5 R7 vsync mismatches vec%0d", idx), m_vs, 0);
        chk($sformatf("R8 R7 csync mismatches vec%0d", idx), m_cs, 0);
        chk($sformatf("R6 R7 blank mismatches vec%0d", idx), m_bl, 0);
        chk($sformatf("R4 R11 pix_valid mismatches vec%0d", idx), m_pv, 0);
        chk($sformatf("R2 eol mismatches vec%0d", idx), m_eol, 0);
        chk($sformatf("R10 eof mismatches vec%0d", idx), m_eof, 0);
    endtask

    initial begin
        // Reset state with a mixed polarity mask (R9)
        {pol_bl, pol_cs, pol_vs, pol_hs} = 4'b1010;
        repeat (3) @(negedge clk);
        chk("R9 reset hsync_o", hsync_o, 0);
        chk("R9 reset vsync_o", vsync_o, 1);
        chk("R9 reset csync_o", csync_o, 0);
        chk("R9 reset blank_o", blank_o, 1);
        chk("R9 reset strobes", {pix_valid_o, eol_o, eof_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 disabled after reset blank_o", blank_o, 1);

        // Main table
        for (int i = 0; i < NVEC; i++) run_vec(i);

        // Disable in mid-line, then restart at position 0 (R9, R11, R3)
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        load_vec(VECS[0]);
        @(negedge clk); en = 1'b1;
        repeat (4) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R9 mid-line disable hsync_o", hsync_o, 0);
        chk("R9 mid-line disable strobes", {pix_valid_o, eol_o, eof_o}, 0);
        en = 1'b1;
        @(negedge clk);
        chk("R11 restart position 0 hsync_o", hsync_o, 1);
        @(negedge clk);
        chk("R3 last sync pixel hsync_o", hsync_o, 1);
        @(negedge clk);
        chk("R3 first pixel after sync hsync_o", hsync_o, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule